// File: doc/BRIEF.md
# Read-Modify-Write Bus Sequencer

This block drives the memory-bus side of the read-modify-write instructions of an 8-bit processor. A start strobe presents several inputs to it: a 16-bit base address, an 8-bit index value, a mode bit that selects absolute or indexed addressing, a 3-bit operation code and the current carry. The block then owns a single-master bus for a fixed run of cycles.

In that run it reads the operand from the effective address and writes the operand back unchanged. One cycle later it writes the modified value to the same address. Every such instruction therefore puts two write cycles on the bus. A device with side effects on write sees the original value first and the new value second.

When the run is over, the block pulses a done flag. It then holds the result, the updated carry and the zero and negative flags until the next run finishes. Instruction fetch, decoding and the operand-address bytes are handled upstream. With those three fetch cycles added, an absolute instruction spans 6 cycles and an indexed one spans 7.

Top module: `rmw_seq`

## Requirements
- R1: The first write cycle comes immediately after the operand read cycle, at the same address. Its write data is the byte that was read.
- R2: The modified value is written in the cycle right after the first write, at the same address. A run contains exactly two write cycles.
- R3: Operation code 0 shifts left and code 2 shifts right. Both fill the vacated bit with 0 and ignore the incoming carry. Carry out is the bit shifted out (bit 7 for left, bit 0 for right), so 0x25 gives 0x4A and 0x12.
- R4: Code 1 rotates left with the incoming carry entering bit 0, and code 3 rotates right with the carry entering bit 7. Carry out is the bit shifted out. For operand 0x25, rotate left gives 0x4A or 0x4B and rotate right gives 0x12 or 0x92, for carry 0 and 1 respectively.
- R5: Code 4 decrements and code 5 increments, both modulo 256, and the carry passes through unchanged. Codes 6 and 7 return the operand unchanged and also pass the carry through.
- R6: With the mode bit at 0, the effective address is the base. With the mode bit at 1, it is (base + index) mod 65536, and the read is preceded by one read-only cycle at address {base[15:8], (base[7:0] + index) mod 256}.
- R7: Busy is high for 3 cycles in absolute mode and 4 in indexed mode, starting the cycle after the start edge.
- R8: Done is high for exactly one cycle, the cycle after the second write. From that cycle on, the result and flags show the new values until the next run completes.
- R9: Write enable is high only in the two write cycles. While idle, the address and write data are 0.
- R10: A start strobe seen while busy is ignored and does not change that run's address, data or result.
- R11: Zero is high when the result is 0, and negative equals result bit 7. After reset the block is idle with result 0, carry 0, zero 1 and negative 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| base_addr | input | 16 | Operand base address |
| index | input | 8 | Index register value |
| indexed | input | 1 | 1 = add index to base |
| op | input | 3 | Operation code (0 shl, 1 rol, 2 shr, 3 ror, 4 dec, 5 inc) |
| carry_in | input | 1 | Incoming carry flag |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | Bus write enable |
| bus_rdata | input | 8 | Bus read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Modified value of the last run |
| carry_out | output | 1 | Updated carry |
| zero | output | 1 | Result is zero |
| negative | output | 1 | Result bit 7 |

## Verification
The assertions assume that the bus returns read data in the same cycle as the address and holds it until the clock edge. The first-write check compares against the byte on the bus in the previous cycle, which only holds if this assumption is true. The bench models the target as a combinational responder, so read data always follows the address in the same cycle. It also raises start only at the falling edge. The sweep covers every operation code, both carry values, all 256 operand values and both addressing modes. The base/index pairs are chosen to cross page boundaries and to wrap at 0xFFFF.

// File: rtl/rmw_seq.sv
module rmw_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] index,
  input  logic          indexed,
  input  logic [2:0]    op,
  input  logic          carry_in,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          carry_out,
  output logic          zero,
  output logic          negative
);
  typedef enum logic [2:0] {S_IDLE, S_IDX, S_RD, S_WO, S_WM} state_t;

  state_t        st;
  logic [AW-1:0] base_q;
  logic [DW-1:0] idx_q, opnd_q, res_q, alu_r;
  logic [2:0]    op_q;
  logic          mode_q, cin_q, cout_q, done_q, alu_c;
  logic [AW-1:0] ea, part;

  assign ea   = mode_q ? base_q + AW'(idx_q) : base_q;
  assign part = {base_q[AW-1:DW], base_q[DW-1:0] + idx_q};

  always_comb begin
    alu_c = cin_q;
    case (op_q)
      3'd0: begin alu_r = {opnd_q[DW-2:0], 1'b0};  alu_c = opnd_q[DW-1]; end
      3'd1: begin alu_r = {opnd_q[DW-2:0], cin_q}; alu_c = opnd_q[DW-1]; end
      3'd2: begin alu_r = {1'b0, opnd_q[DW-1:1]};  alu_c = opnd_q[0]; end
      3'd3: begin alu_r = {cin_q, opnd_q[DW-1:1]}; alu_c = opnd_q[0]; end
      3'd4: alu_r = opnd_q - 1'b1;
      3'd5: alu_r = opnd_q + 1'b1;
      default: alu_r = opnd_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      op_q   <= '0;
      mode_q <= 1'b0;
      cin_q  <= 1'b0;
      opnd_q <= '0;
      res_q  <= '0;
      cout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st == S_WM);
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_addr;
          idx_q  <= index;
          op_q   <= op;
          mode_q <= indexed;
          cin_q  <= carry_in;
          st     <= indexed ? S_IDX : S_RD;
        end
        S_IDX: st <= S_RD;
        S_RD: begin
          opnd_q <= bus_rdata;
          st     <= S_WO;
        end
        S_WO: st <= S_WM;
        S_WM: begin
          res_q  <= alu_r;
          cout_q <= alu_c;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    case (st)
      S_IDX: bus_addr = part;
      S_RD:  bus_addr = ea;
      S_WO: begin bus_addr = ea; bus_wdata = opnd_q; bus_we = 1'b1; end
      S_WM: begin bus_addr = ea; bus_wdata = alu_r;  bus_we = 1'b1; end
      default: ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign result    = res_q;
  assign carry_out = cout_q;
  assign zero      = (res_q == '0);
  assign negative  = res_q[DW-1];
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic [DW-1:0] index,
  input logic          indexed,
  input logic [2:0]    op,
  input logic          carry_in,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_we,
  input logic [DW-1:0] bus_rdata,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result,
  input logic          carry_out,
  input logic          zero,
  input logic          negative
);
  AST_FIRST_WRITE_ORIG: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_we) |-> bus_wdata == $past(bus_rdata) && bus_addr == $past(bus_addr)); // R1
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_we) |=> bus_we && $stable(bus_addr)); // R2
  AST_NO_THIRD_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bus_we && $past(bus_we) |=> !bus_we); // R2
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(bus_we) && !busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_we |-> busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> bus_addr == '0 && bus_wdata == '0); // R9
  AST_FLAGS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) zero == (result == '0) && negative == result[DW-1]); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result) && $stable(carry_out)); // R8
endmodule

bind rmw_seq rmw_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_rmw_seq.sv
module test_rmw_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, indexed = 1'b0, carry_in = 1'b0;
  logic [15:0] base_addr = '0;
  logic [7:0]  index = '0;
  logic [2:0]  op = '0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, result;
  logic        bus_we, busy, done, carry_out, zero, negative;
  logic [15:0] tgt = '0;
  logic [7:0]  mem = '0;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  assign bus_rdata = (bus_addr == tgt) ? mem : 8'hC3;

  rmw_seq i_rmw_seq (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input int o, input int v, input int c);
    int r, co;
    co = c;
    case (o)
      0: begin r = (v * 2) % 256;     co = v / 128; end
      1: begin r = (v * 2 + c) % 256; co = v / 128; end
      2: begin r = v / 2;             co = v % 2; end
      3: begin r = v / 2 + 128 * c;   co = v % 2; end
      4: r = (v + 255) % 256;
      5: r = (v + 1) % 256;
      default: r = v;
    endcase
    return {co[0], r[7:0]};
  endfunction

  task automatic run(input int o, input int v, input int c, input bit m,
                     input logic [15:0] b, input logic [7:0] ix, input bit poke);
    logic [8:0] e;
    e = model(o, v, c);
    tgt = m ? b + {8'h00, ix} : b;
    mem = v[7:0];
    base_addr = b; index = ix; indexed = m; op = o[2:0]; carry_in = c[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R7", "busy first cycle", busy, 1);
    if (m) begin
      chk(!bus_we && bus_addr == {b[15:8], b[7:0] + ix}, "R6", "partial addr cycle", bus_addr, {b[15:8], b[7:0] + ix});
      @(negedge clk);
      chk(busy, "R7", "busy indexed", busy, 1);
    end
    chk(!bus_we && bus_addr == tgt, "R6", "read addr", bus_addr, tgt);
    if (poke) begin
      start = 1'b1; op = 3'(o + 1); carry_in = ~c[0]; base_addr = ~b; indexed = ~m;
    end
    @(negedge clk);
    start = 1'b0;
    chk(bus_we && bus_addr == tgt, "R1", "first write addr", bus_addr, tgt);
    chk(bus_wdata == v[7:0], "R1", "first write data", bus_wdata, v);
    @(negedge clk);
    chk(bus_we && bus_addr == tgt, "R2", "second write addr", bus_addr, tgt);
    chk(bus_wdata == e[7:0], o < 2 ? "R3" : (o < 4 ? "R4" : "R5"), "second write data", bus_wdata, e[7:0]);
    @(negedge clk);
    chk(done && !busy && !bus_we, "R8", "done pulse", {done, busy, bus_we}, 3'b100);
    chk(result == e[7:0], poke ? "R10" : "R8", "result", result, e[7:0]);
    chk(carry_out == e[8], o < 4 ? "R3" : "R5", "carry out", carry_out, e[8]);
    chk(zero == (e[7:0] == 0) && negative == e[7], "R11", "flags", {zero, negative}, {e[7:0] == 0, e[7]});
    @(negedge clk);
    chk(!done && bus_addr == 0 && bus_wdata == 0 && !bus_we, "R9", "idle after done", {done, bus_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_we && result == 0 && !carry_out && zero && !negative,
        "R11", "reset state", {busy, done, bus_we, result, carry_out, zero, negative}, 10'h002);
    run(1, 8'h25, 0, 0, 16'h254A, 0, 0);
    chk(result == 8'h4A, "R4", "rol 25 c0", result, 8'h4A);
    run(1, 8'h25, 1, 0, 16'h254A, 0, 0);
    chk(result == 8'h4B, "R4", "rol 25 c1", result, 8'h4B);
    run(3, 8'h25, 0, 0, 16'h2512, 0, 0);
    chk(result == 8'h12, "R4", "ror 25 c0", result, 8'h12);
    run(3, 8'h25, 1, 0, 16'h2512, 0, 0);
    chk(result == 8'h92, "R4", "ror 25 c1", result, 8'h92);
    run(0, 8'h25, 1, 0, 16'h254A, 0, 0);
    chk(result == 8'h4A, "R3", "shl 25 ignores carry", result, 8'h4A);
    run(2, 8'h25, 1, 0, 16'h2512, 0, 0);
    chk(result == 8'h12, "R3", "shr 25 ignores carry", result, 8'h12);
    run(5, 8'hFF, 1, 1, 16'hFFF0, 8'h20, 0);
    run(4, 8'h00, 0, 1, 16'h25FA, 8'h06, 0);
    for (int k = 0; k < 6; k++) run(k, 8'h81 + k, k % 2, k % 2, 16'h25FA, 8'h06, 1);
    for (int o = 0; o < 8; o++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 256; v++)
          run(o, v, c, v[0], {v[7:0], v[7:0] ^ 8'hA5}, 8'(v * 3 + o), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule